// File: doc/BRIEF.md
# Second-Operand Shifter with Carry

This block forms the second operand of a data-processing operation, together with the carry that a flag-setting operation would take from the shifter. It is purely combinational. It has two paths. The register path takes a 32-bit source word and applies a logical left, logical right, arithmetic right or rotate right shift. The shift count comes either from a 5-bit field in the instruction or from the low byte of a second register. The immediate path takes an 8-bit constant, extends it with zeros and rotates it right by twice a 4-bit rotate field.

The current carry flag is an input. It supplies the carry-out when no bit is shifted out, and it is the bit moved into the top position by the rotate-through-carry form. The caller decodes the instruction into the select, kind and amount inputs. The caller also chooses whether to use `carry_o`.

Top module: `operand_shifter`

## Requirements
- R1: With `imm_mode_i` = 1, `operand_o` equals `imm_val_i` zero-extended to 32 bits and rotated right by 2 × `imm_rot_i` bit positions.
- R2: With `imm_mode_i` = 1, `carry_o` equals bit 31 of `operand_o` when `imm_rot_i` is nonzero, and equals `carry_i` when it is zero.
- R3: `kind_i` is encoded 2'b00 left logical, 2'b01 right logical, 2'b10 right arithmetic, 2'b11 rotate right. For a count n from 1 to 31, the result is the shifted word and `carry_o` is the last bit shifted out (bit 32−n for a left shift, bit n−1 otherwise).
- R4: With `amt_sel_reg_i` = 1, the count is `amt_reg_i[7:0]`, and bits [31:8] of `amt_reg_i` have no effect.
- R5: A register count of 0 passes `src_i` through unchanged with `carry_o` = `carry_i`, for every kind.
- R6: A left logical shift by 32 gives 0 with carry = `src_i[0]`. A count above 32 gives 0 with carry 0.
- R7: A right logical shift by 32 gives 0 with carry = `src_i[31]`. A count above 32 gives 0 with carry 0.
- R8: A right arithmetic shift by 32 or more fills every bit with `src_i[31]`, and carry = `src_i[31]`.
- R9: A rotate by a register count that is a nonzero multiple of 32 leaves `src_i` unchanged with carry = `src_i[31]`. Any other nonzero count rotates by the count modulo 32, with carry = bit 31 of the result.
- R10: With `amt_sel_reg_i` = 0, a field `amt_imm_i` of 0 means: for a left shift, pass through with carry = `carry_i`; for a right logical or right arithmetic shift, a count of 32.
- R11: With `amt_sel_reg_i` = 0, a rotate with `amt_imm_i` = 0 rotates through carry: the result is {`carry_i`, `src_i[31:1]`} and carry = `src_i[0]`.
- R12: With `imm_mode_i` = 1, `src_i`, `kind_i`, `amt_sel_reg_i`, `amt_imm_i` and `amt_reg_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode_i | input | 1 | 1 selects the rotated-constant path |
| imm_val_i | input | 8 | Constant for the immediate path |
| imm_rot_i | input | 4 | Rotate field; rotate amount is twice this value |
| src_i | input | 32 | Word to shift on the register path |
| kind_i | input | 2 | Shift kind (see R3) |
| amt_sel_reg_i | input | 1 | 1 takes the count from a register, 0 from the instruction field |
| amt_imm_i | input | 5 | Instruction-field shift count |
| amt_reg_i | input | 32 | Register holding the shift count in its low byte |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifted or rotated operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Counts from 1 to 31 are applied to each kind on several bit patterns. Because the carry is the last bit shifted out, this separates an off-by-one in the carry tap from a shift in the wrong direction. Register counts of exactly 32, just above 32, 255 and rotate multiples of 32 probe the edges where each kind follows its own rule. A count with upper register bits set checks that only the low byte is used. Instruction-field counts of zero are checked for each kind, which separates the pass-through form, the count-of-32 forms and rotate-through-carry. Immediate rotates of zero and nonzero, with both carry inputs, show when the input flag passes through and when bit 31 of the result is used instead.

// File: rtl/operand_shifter_pkg.sv
`timescale 1ns/1ps
package operand_shifter_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/operand_amount_dec.sv
`timescale 1ns/1ps
module operand_amount_dec
  import operand_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int SH_W   = 5
) (
  input  shift_kind_e        kind_i,
  input  logic               sel_reg_i,
  input  logic [SH_W-1:0]    amt_imm_i,
  input  logic [AMT_W-1:0]   amt_reg_i,
  output logic [AMT_W-1:0]   amt_o,
  output logic               rrx_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  always_comb begin
    rrx_o = 1'b0;
    amt_o = '0;
    if (sel_reg_i) begin
      amt_o = amt_reg_i;
    end else if (amt_imm_i != '0) begin
      amt_o = AMT_W'(amt_imm_i);
    end else begin
      // zero field: per-kind meaning
      unique case (kind_i)
        SK_LSL:         amt_o = '0;
        SK_LSR, SK_ASR: amt_o = FULL_AMT;
        SK_ROR:         rrx_o = 1'b1;
        default:        amt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/operand_reg_shifter.sv
`timescale 1ns/1ps
module operand_reg_shifter
  import operand_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              carry_i,
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              rrx_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int SH_W   = $clog2(DATA_W);
  localparam int CLIP_W = $clog2(DATA_W + 2);
  localparam logic [AMT_W-1:0]  OVER_AMT = AMT_W'(DATA_W + 1);
  localparam logic [AMT_W-1:0]  FULL_AMT = AMT_W'(DATA_W);
  localparam logic [CLIP_W-1:0] OVER_C   = CLIP_W'(DATA_W + 1);
  localparam logic [CLIP_W-1:0] FULL_C   = CLIP_W'(DATA_W);

  logic [CLIP_W-1:0]        amt_log;
  logic [CLIP_W-1:0]        amt_ari;
  logic [SH_W-1:0]          amt_rot;
  logic [DATA_W:0]          lsl_w;
  logic [DATA_W:0]          lsr_w;
  logic signed [DATA_W:0]   asr_w;
  logic [2*DATA_W-1:0]      ror_w;
  logic [DATA_W-1:0]        ror_res;

  // saturate counts: logical shifts stop at DATA_W+1, arithmetic at DATA_W
  assign amt_log = (amt_i >= OVER_AMT) ? OVER_C : amt_i[CLIP_W-1:0];
  assign amt_ari = (amt_i >= FULL_AMT) ? FULL_C : amt_i[CLIP_W-1:0];
  assign amt_rot = amt_i[SH_W-1:0];

  // one guard bit carries the last bit shifted out
  assign lsl_w   = {1'b0, val_i} << amt_log;
  assign lsr_w   = {val_i, 1'b0} >> amt_log;
  assign asr_w   = $signed({val_i, 1'b0}) >>> amt_ari;
  assign ror_w   = {val_i, val_i} >> amt_rot;
  assign ror_res = ror_w[DATA_W-1:0];

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, val_i[DATA_W-1:1]};
      carry_o = val_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        SK_LSL: begin
          res_o   = lsl_w[DATA_W-1:0];
          carry_o = lsl_w[DATA_W];
        end
        SK_LSR: begin
          res_o   = lsr_w[DATA_W:1];
          carry_o = lsr_w[0];
        end
        SK_ASR: begin
          res_o   = asr_w[DATA_W:1];
          carry_o = asr_w[0];
        end
        SK_ROR: begin
          res_o   = ror_res;
          carry_o = ror_res[DATA_W-1];
        end
        default: begin
          res_o   = val_i;
          carry_o = carry_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_imm_rotator.sv
`timescale 1ns/1ps
module operand_imm_rotator #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int RAMT_W = ROT_W + 1;

  logic [DATA_W-1:0]   ext;
  logic [RAMT_W-1:0]   ramt;
  logic [2*DATA_W-1:0] dbl;

  assign ext     = DATA_W'(imm_i);
  assign ramt    = {rot_i, 1'b0};
  assign dbl     = {ext, ext} >> ramt;
  assign res_o   = dbl[DATA_W-1:0];
  assign carry_o = (rot_i != '0) ? dbl[DATA_W-1] : carry_i;
endmodule

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter
  import operand_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8
) (
  input  logic                        imm_mode_i,
  input  logic [IMM_W-1:0]            imm_val_i,
  input  logic [ROT_W-1:0]            imm_rot_i,
  input  logic [DATA_W-1:0]           src_i,
  input  logic [1:0]                  kind_i,
  input  logic                        amt_sel_reg_i,
  input  logic [$clog2(DATA_W)-1:0]   amt_imm_i,
  input  logic [DATA_W-1:0]           amt_reg_i,
  input  logic                        carry_i,
  output logic [DATA_W-1:0]           operand_o,
  output logic                        carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt_eff;
  logic              rrx;
  logic [DATA_W-1:0] reg_res;
  logic              reg_c;
  logic [DATA_W-1:0] imm_res;
  logic              imm_c;

  assign kind = shift_kind_e'(kind_i);

  operand_amount_dec #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .SH_W   (SH_W)
  ) u_amt (
    .kind_i    (kind),
    .sel_reg_i (amt_sel_reg_i),
    .amt_imm_i (amt_imm_i),
    .amt_reg_i (amt_reg_i[AMT_W-1:0]),
    .amt_o     (amt_eff),
    .rrx_o     (rrx)
  );

  operand_reg_shifter #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_reg (
    .val_i   (src_i),
    .carry_i (carry_i),
    .kind_i  (kind),
    .amt_i   (amt_eff),
    .rrx_i   (rrx),
    .res_o   (reg_res),
    .carry_o (reg_c)
  );

  operand_imm_rotator #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_imm (
    .imm_i   (imm_val_i),
    .rot_i   (imm_rot_i),
    .carry_i (carry_i),
    .res_o   (imm_res),
    .carry_o (imm_c)
  );

  assign operand_o = imm_mode_i ? imm_res : reg_res;
  assign carry_o   = imm_mode_i ? imm_c   : reg_c;
endmodule

// File: rtl/operand_shifter_chk.sv
`timescale 1ns/1ps
module operand_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8
) (
  input logic                      imm_mode_i,
  input logic [IMM_W-1:0]          imm_val_i,
  input logic [ROT_W-1:0]          imm_rot_i,
  input logic [DATA_W-1:0]         src_i,
  input logic [1:0]                kind_i,
  input logic                      amt_sel_reg_i,
  input logic [$clog2(DATA_W)-1:0] amt_imm_i,
  input logic [DATA_W-1:0]         amt_reg_i,
  input logic                      carry_i,
  input logic [DATA_W-1:0]         operand_o,
  input logic                      carry_o
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
  localparam int SH_W = $clog2(DATA_W);

  logic [AMT_W-1:0] ramt;
  logic             known;
  logic             regp;

  assign ramt  = amt_reg_i[AMT_W-1:0];
  assign regp  = !imm_mode_i && amt_sel_reg_i;
  assign known = !$isunknown({imm_mode_i, imm_val_i, imm_rot_i, src_i, kind_i,
                              amt_sel_reg_i, amt_imm_i, amt_reg_i, carry_i,
                              operand_o, carry_o});

  always_comb begin
    if (known) begin
      // R1
      imm_norot_chk: assert (!(imm_mode_i && imm_rot_i == '0) ||
                             (operand_o == DATA_W'(imm_val_i) && carry_o == carry_i))
        else $error("immediate without rotate altered");
      // R5
      zero_pass_chk: assert (!(regp && ramt == '0) ||
                             (operand_o == src_i && carry_o == carry_i))
        else $error("zero count not a pass-through");
      // R6
      lsl_over_chk: assert (!(regp && kind_i == 2'b00 && ramt > FULL_AMT) ||
                            (operand_o == '0 && !carry_o))
        else $error("left shift above width not cleared");
      // R8
      asr_fill_chk: assert (!(regp && kind_i == 2'b10 && ramt >= FULL_AMT) ||
                            (operand_o == {DATA_W{src_i[DATA_W-1]}} &&
                             carry_o == src_i[DATA_W-1]))
        else $error("arithmetic shift fill wrong");
      // R9
      ror_mult_chk: assert (!(regp && kind_i == 2'b11 && ramt != '0 &&
                              ramt[SH_W-1:0] == '0) ||
                            (operand_o == src_i && carry_o == src_i[DATA_W-1]))
        else $error("rotate by width multiple wrong");
      // R11
      rrx_chk: assert (!(!imm_mode_i && !amt_sel_reg_i && kind_i == 2'b11 &&
                         amt_imm_i == '0) ||
                       (operand_o[DATA_W-1] == carry_i && carry_o == src_i[0]))
        else $error("rotate through carry wrong");
    end
  end
endmodule

bind operand_shifter operand_shifter_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .ROT_W  (ROT_W),
  .AMT_W  (AMT_W)
) u_chk (
  .imm_mode_i    (imm_mode_i),
  .imm_val_i     (imm_val_i),
  .imm_rot_i     (imm_rot_i),
  .src_i         (src_i),
  .kind_i        (kind_i),
  .amt_sel_reg_i (amt_sel_reg_i),
  .amt_imm_i     (amt_imm_i),
  .amt_reg_i     (amt_reg_i),
  .carry_i       (carry_i),
  .operand_o     (operand_o),
  .carry_o       (carry_o)
);

// File: tb/operand_shifter_tb.sv
`timescale 1ns/1ps
module operand_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        imm_mode_i = 1'b0;
  logic [7:0]  imm_val_i = '0;
  logic [3:0]  imm_rot_i = '0;
  logic [31:0] src_i = '0;
  logic [1:0]  kind_i = '0;
  logic        amt_sel_reg_i = 1'b0;
  logic [4:0]  amt_imm_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] operand_o;
  logic        carry_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  operand_shifter u_dut (
    .imm_mode_i    (imm_mode_i),
    .imm_val_i     (imm_val_i),
    .imm_rot_i     (imm_rot_i),
    .src_i         (src_i),
    .kind_i        (kind_i),
    .amt_sel_reg_i (amt_sel_reg_i),
    .amt_imm_i     (amt_imm_i),
    .amt_reg_i     (amt_reg_i),
    .carry_i       (carry_i),
    .operand_o     (operand_o),
    .carry_o       (carry_o)
  );

  // bit-serial reference: {carry, result}
  function automatic logic [32:0] ref_reg(logic [1:0] k, logic sel, logic [4:0] ai,
                                          logic [31:0] ar, logic [31:0] v, logic ci);
    int n = 0;
    logic c = ci;
    logic [31:0] w = v;
    if (sel) n = int'(ar[7:0]);
    else if (ai != 0) n = int'(ai);
    else if (k == 2'b01 || k == 2'b10) n = 32;
    else if (k == 2'b11) return {v[0], ci, v[31:1]};
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = w[31]; w = {w[30:0], 1'b0}; end
        2'b01: begin c = w[0];  w = {1'b0, w[31:1]}; end
        2'b10: begin c = w[0];  w = {w[31], w[31:1]}; end
        default: begin c = w[0]; w = {w[0], w[31:1]}; end
      endcase
    end
    return {c, w};
  endfunction

  function automatic logic [32:0] ref_imm(logic [7:0] im, logic [3:0] r, logic ci);
    logic [31:0] w = {24'h0, im};
    for (int i = 0; i < 2 * int'(r); i++) w = {w[0], w[31:1]};
    return {(r != 0) ? w[31] : ci, w};
  endfunction

  task automatic check(string req, logic [32:0] exp);
    @(negedge clk);
    n_run++;
    if ({carry_o, operand_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: actual op=%h c=%b expected op=%h c=%b",
               req, operand_o, carry_o, exp[31:0], exp[32]);
    end
  endtask

  task automatic drive_reg(logic [1:0] k, logic sel, logic [4:0] ai, logic [31:0] ar,
                           logic [31:0] v, logic ci);
    @(posedge clk);
    imm_mode_i = 1'b0; kind_i = k; amt_sel_reg_i = sel; amt_imm_i = ai;
    amt_reg_i = ar; src_i = v; carry_i = ci;
  endtask

  task automatic run_reg(string req, logic [1:0] k, logic sel, logic [4:0] ai,
                         logic [31:0] ar, logic [31:0] v, logic ci);
    drive_reg(k, sel, ai, ar, v, ci);
    check(req, ref_reg(k, sel, ai, ar, v, ci));
  endtask

  task automatic run_imm(string req, logic [7:0] im, logic [3:0] r, logic ci);
    @(posedge clk);
    imm_mode_i = 1'b1; imm_val_i = im; imm_rot_i = r; carry_i = ci;
    check(req, ref_imm(im, r, ci));
  endtask

  task automatic t_reset;
    check("R5 reset state", 33'h0);
  endtask

  task automatic t_imm_path;
    run_imm("R1 R2 rot0", 8'hFF, 4'd0, 1'b1);
    @(posedge clk); imm_val_i = 8'hFF; imm_rot_i = 4'd1; carry_i = 1'b0;
    check("R1 R2 rot1 literal", {1'b1, 32'hC000_003F});
    run_imm("R1 R2 rot4", 8'hFF, 4'd4, 1'b0);
    run_imm("R2 bit31 clear cin1", 8'h01, 4'd1, 1'b1);
    run_imm("R1 rot15", 8'h3F, 4'd15, 1'b1);
    run_imm("R2 rot0 cin0", 8'h80, 4'd0, 1'b0);
  endtask

  task automatic t_small_shifts;
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h5A3C_96E1, 32'h7FFF_FFFE};
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 3; p++)
        for (int a = 1; a < 32; a += 5) begin
          run_reg("R3 reg count", 2'(k), 1'b1, 5'd0, 32'(a), pats[p], 1'(p));
          run_reg("R3 field count", 2'(k), 1'b0, 5'(a), 32'h0, pats[p], 1'(p));
        end
  endtask

  task automatic t_lsl_edges;
    run_reg("R6 lsl 32", 2'b00, 1'b1, 5'd0, 32'd32, 32'h0000_0001, 1'b0);
    drive_reg(2'b00, 1'b1, 5'd0, 32'd32, 32'hFFFF_FFFE, 1'b1);
    check("R6 lsl 32 literal", 33'h0);
    run_reg("R6 lsl 33", 2'b00, 1'b1, 5'd0, 32'd33, 32'hFFFF_FFFF, 1'b1);
    run_reg("R6 lsl 200", 2'b00, 1'b1, 5'd0, 32'd200, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_lsr_edges;
    drive_reg(2'b01, 1'b1, 5'd0, 32'd32, 32'h8000_0000, 1'b0);
    check("R7 lsr 32 literal", {1'b1, 32'h0});
    run_reg("R7 lsr 32 b31 clear", 2'b01, 1'b1, 5'd0, 32'd32, 32'h7FFF_FFFF, 1'b1);
    run_reg("R7 lsr 33", 2'b01, 1'b1, 5'd0, 32'd33, 32'hFFFF_FFFF, 1'b1);
    run_reg("R7 lsr 255", 2'b01, 1'b1, 5'd0, 32'd255, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_asr_edges;
    drive_reg(2'b10, 1'b1, 5'd0, 32'd40, 32'h8000_0000, 1'b0);
    check("R8 asr 40 literal", {1'b1, 32'hFFFF_FFFF});
    run_reg("R8 asr 32 neg", 2'b10, 1'b1, 5'd0, 32'd32, 32'h9000_0000, 1'b0);
    run_reg("R8 asr 32 pos", 2'b10, 1'b1, 5'd0, 32'd32, 32'h7FFF_FFFF, 1'b1);
    run_reg("R8 asr 255", 2'b10, 1'b1, 5'd0, 32'd255, 32'hC000_0000, 1'b0);
  endtask

  task automatic t_ror_edges;
    drive_reg(2'b11, 1'b1, 5'd0, 32'd64, 32'h8000_1234, 1'b0);
    check("R9 ror 64 literal", {1'b1, 32'h8000_1234});
    run_reg("R9 ror 32", 2'b11, 1'b1, 5'd0, 32'd32, 32'h1234_5678, 1'b1);
    run_reg("R9 ror 224", 2'b11, 1'b1, 5'd0, 32'd224, 32'hF000_000F, 1'b0);
    run_reg("R9 ror 33", 2'b11, 1'b1, 5'd0, 32'd33, 32'h0000_0001, 1'b0);
    run_reg("R9 ror 63", 2'b11, 1'b1, 5'd0, 32'd63, 32'hC000_0001, 1'b1);
  endtask

  task automatic t_zero_count;
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++) begin
        drive_reg(2'(k), 1'b1, 5'd7, 32'h0, 32'hA5A5_0F0F, 1'(c));
        check("R5 zero count", {1'(c), 32'hA5A5_0F0F});
      end
  endtask

  task automatic t_upper_bits;
    drive_reg(2'b00, 1'b1, 5'd0, 32'h0000_0100, 32'h1357_9BDF, 1'b1);
    check("R4 upper bits ignored pass", {1'b1, 32'h1357_9BDF});
    run_reg("R4 upper bits ignored shift", 2'b01, 1'b1, 5'd0, 32'hFFFF_FF04,
            32'hF000_0008, 1'b0);
  endtask

  task automatic t_field_zero;
    drive_reg(2'b00, 1'b0, 5'd0, 32'd5, 32'hDEAD_BEEF, 1'b1);
    check("R10 lsl field 0", {1'b1, 32'hDEAD_BEEF});
    drive_reg(2'b01, 1'b0, 5'd0, 32'd3, 32'h8000_0000, 1'b0);
    check("R10 lsr field 0", {1'b1, 32'h0});
    drive_reg(2'b10, 1'b0, 5'd0, 32'd3, 32'h8000_0000, 1'b0);
    check("R10 asr field 0", {1'b1, 32'hFFFF_FFFF});
    run_reg("R10 lsr field 1", 2'b01, 1'b0, 5'd1, 32'd0, 32'h0000_0003, 1'b0);
  endtask

  task automatic t_rrx;
    drive_reg(2'b11, 1'b0, 5'd0, 32'd8, 32'h0000_0003, 1'b1);
    check("R11 rrx cin1", {1'b1, 32'h8000_0001});
    drive_reg(2'b11, 1'b0, 5'd0, 32'd8, 32'h8000_0002, 1'b0);
    check("R11 rrx cin0", {1'b0, 32'h4000_0001});
    run_reg("R11 ror field 4", 2'b11, 1'b0, 5'd4, 32'd0, 32'h0000_001F, 1'b0);
  endtask

  task automatic t_imm_ignores_reg;
    logic [32:0] e = ref_imm(8'h9C, 4'd3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      imm_mode_i = 1'b1; imm_val_i = 8'h9C; imm_rot_i = 4'd3; carry_i = 1'b1;
      src_i = 32'h1111_1111 * (i + 1); kind_i = 2'(i); amt_sel_reg_i = 1'(i);
      amt_imm_i = 5'(i * 7); amt_reg_i = 32'(i * 40);
      check("R12 reg inputs ignored", e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    t_reset();
    t_imm_path();
    t_small_shifts();
    t_lsl_edges();
    t_lsr_edges();
    t_asr_edges();
    t_ror_edges();
    t_zero_count();
    t_upper_bits();
    t_field_zero();
    t_rrx();
    t_imm_ignores_reg();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule